// File: doc/BRIEF.md
# Indexed Display Register Port

This block is the register front end of a display adapter. Software reaches a file of 32-bit registers through two ports. It first writes a register number to the index port. Reads and writes on the value port then go to the register that the index selects. A third, auxiliary port reads as zero and ignores writes. Any other offset reads as all ones.

The file holds the following state:
- a version handshake word;
- the enable and configuration-done flags;
- the requested mode width and height;
- a guest identifier;
- the cursor id, x position, y position and visibility;
- a scratch array of `SCRATCH_WORDS` words.

Fixed limits, capabilities and sizes read back as constants. The display-mode words are derived from the requested width and the host pixel depth. The enable flag, the configuration flag and a one-cycle sync pulse are driven to a command processor. The command processor answers the pulse with `cmdDone`, which clears the busy flag.

Port offsets are 0 (index), 1 (value) and 2 (auxiliary), each multiplied by the parameter `STRIDE` (1 or 4). The register numbers are fixed by the programming model, as listed in the requirements. Reads take effect one cycle after the request.

Top module: `disp_idx_port`

## Requirements
- R1: After reset the block holds the following. The version word is 0x90000002. Enable, config and busy are 0. Width is 640 and height is 480. The index is 0 and all cursor fields are 0.
- R2: A write at offset 0 sets the index, and a read at offset 0 returns it. A value-port access is at offset STRIDE. An auxiliary read at offset 2*STRIDE returns 0, and an auxiliary write changes nothing. A read at any other offset returns 0xFFFFFFFF.
- R3: A write to register 0 is kept only if the value is 0x90000000, 0x90000001 or 0x90000002. Any other value leaves the register unchanged.
- R4: A write to register 2 (width) is kept only if the value is at most 2368. A write to register 3 (height) is kept only if the value is at most 1770. A larger value leaves the register unchanged.
- R5: The read-only registers return fixed or derived values:
  - register 4 returns 2368 and register 5 returns 1770;
  - register 6 returns the host depth, or 24 when the depth is 32;
  - register 7 returns the host depth;
  - register 12 returns depth × width / 8;
  - register 17 returns CAPS_WORD (default 0xE3) and register 19 returns MEM_BYTES (default 0x10000);
  - register 29 returns SCRATCH_WORDS (default 64).
- R6: A nonzero write sets the flag and a zero write clears it, for register 1 (enable) and register 20 (config). Each flag reads back as 0 or 1. `dispEnable` and `dispConfig` follow in the cycle after the write.
- R7: A write to register 21 raises `syncPulse` for exactly one cycle and sets busy. Register 22 reads busy. `cmdDone` clears busy. A sync write and `cmdDone` in the same cycle leave busy set.
- R8: Register 27 (cursor on) works as follows. Value 1 sets the flag and value 0 clears it. Any other value, including 2 and 3, leaves the flag unchanged.
- R9: Registers 23 (guest id), 24 (cursor id), 25 (cursor x) and 26 (cursor y) store and return full 32-bit values.
- R10: Indices 1792 up to 1792+SCRATCH_WORDS-1 are scratch words that are written and read back. Indices 1024 to 1791 (palette) read 0 without error and ignore writes.
- R11: A value-port read of an unmapped index returns 0 and raises `rdErr` for one cycle, together with `rdValid`. Unmapped indices include 8 and 1792+SCRATCH_WORDS. Mapped reads never raise `rdErr`.
- R12: `rdValid` and `rdData` appear in the cycle after a read request and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Port offset |
| busWData | input | 32 | Write data |
| cmdDone | input | 1 | Command processor finished; clears busy |
| rdValid | output | 1 | Read data valid |
| rdData | output | 32 | Read data |
| rdErr | output | 1 | Unmapped index was read |
| dispEnable | output | 1 | Enable flag |
| dispConfig | output | 1 | Configuration-done flag |
| syncPulse | output | 1 | One-cycle request to process commands |

## Verification
Random width and height values on both sides of the limits show whether each write was kept or dropped; values exactly at the limit and one above it separate an off-by-one bound. Random cursor-on codes from 0 to 5 separate the set, clear and leave-alone cases. Random scratch addresses with random data expose address aliasing, and the palette range, the index just past the scratch array and the unused numbers below 1024 separate silent zero reads from error reads. The sync write is also tried together with `cmdDone` in the same cycle, to show which of the two wins.

// File: rtl/disp_idx_pkg.sv
package disp_idx_pkg;

  localparam logic [31:0] REG_ID          = 32'd0;
  localparam logic [31:0] REG_ENABLE      = 32'd1;
  localparam logic [31:0] REG_WIDTH       = 32'd2;
  localparam logic [31:0] REG_HEIGHT      = 32'd3;
  localparam logic [31:0] REG_MAX_W       = 32'd4;
  localparam logic [31:0] REG_MAX_H       = 32'd5;
  localparam logic [31:0] REG_DEPTH       = 32'd6;
  localparam logic [31:0] REG_BPP         = 32'd7;
  localparam logic [31:0] REG_LINE_BYTES  = 32'd12;
  localparam logic [31:0] REG_CAPS        = 32'd17;
  localparam logic [31:0] REG_MEM_SIZE    = 32'd19;
  localparam logic [31:0] REG_CONFIG      = 32'd20;
  localparam logic [31:0] REG_SYNC        = 32'd21;
  localparam logic [31:0] REG_BUSY        = 32'd22;
  localparam logic [31:0] REG_GUEST       = 32'd23;
  localparam logic [31:0] REG_CUR_ID      = 32'd24;
  localparam logic [31:0] REG_CUR_X       = 32'd25;
  localparam logic [31:0] REG_CUR_Y       = 32'd26;
  localparam logic [31:0] REG_CUR_ON      = 32'd27;
  localparam logic [31:0] REG_SCR_SIZE    = 32'd29;

  localparam logic [31:0] PAL_FIRST       = 32'd1024;
  localparam logic [31:0] PAL_LAST        = 32'd1791;
  localparam logic [31:0] SCR_BASE        = 32'd1792;

  localparam logic [31:0] VER_0           = 32'h9000_0000;
  localparam logic [31:0] VER_1           = 32'h9000_0001;
  localparam logic [31:0] VER_2           = 32'h9000_0002;

  localparam logic [31:0] LIMIT_W         = 32'd2368;
  localparam logic [31:0] LIMIT_H         = 32'd1770;

  typedef enum logic [1:0] {
    RD_INDEX = 2'd0,
    RD_VALUE = 2'd1,
    RD_AUX   = 2'd2,
    RD_NONE  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic wrId;
    logic wrEnable;
    logic wrWidth;
    logic wrHeight;
    logic wrConfig;
    logic wrSync;
    logic wrGuest;
    logic wrCurId;
    logic wrCurX;
    logic wrCurY;
    logic wrCurOn;
    logic wrScratch;
    logic rdLoad;
  } dispStrobe_t;

  function automatic logic inScratch(input logic [31:0] idx, input logic [31:0] words);
    return (idx >= SCR_BASE) && (idx < SCR_BASE + words);
  endfunction

  function automatic logic idxMapped(input logic [31:0] idx, input logic [31:0] words);
    logic hit;
    case (idx)
      REG_ID, REG_ENABLE, REG_WIDTH, REG_HEIGHT, REG_MAX_W, REG_MAX_H,
      REG_DEPTH, REG_BPP, REG_LINE_BYTES, REG_CAPS, REG_MEM_SIZE,
      REG_CONFIG, REG_SYNC, REG_BUSY, REG_GUEST, REG_CUR_ID, REG_CUR_X,
      REG_CUR_Y, REG_CUR_ON, REG_SCR_SIZE: hit = 1'b1;
      default: hit = ((idx >= PAL_FIRST) && (idx <= PAL_LAST)) || inScratch(idx, words);
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/disp_idx_ctrl.sv
module disp_idx_ctrl
  import disp_idx_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int STRIDE        = 1,
  parameter int SCRATCH_WORDS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWData,
  output dispStrobe_t       stb,
  output rdSel_e            rdSel,
  output logic [31:0]       indexQ,
  output logic              rdValid,
  output logic              rdErr,
  output logic              syncPulse
);

  localparam logic [ADDR_W-1:0] OFF_INDEX = '0;
  localparam logic [ADDR_W-1:0] OFF_VALUE = ADDR_W'(STRIDE);
  localparam logic [ADDR_W-1:0] OFF_AUX   = ADDR_W'(2 * STRIDE);
  localparam logic [31:0]       SCR_WORDS = 32'(SCRATCH_WORDS);

  logic hitIndex, hitValue, hitAux;
  logic valueWr, isRead, mapped;

  assign hitIndex = (busAddr == OFF_INDEX);
  assign hitValue = (busAddr == OFF_VALUE);
  assign hitAux   = (busAddr == OFF_AUX);
  assign valueWr  = busValid && busWrite && hitValue;
  assign isRead   = busValid && !busWrite;
  assign mapped   = idxMapped(indexQ, SCR_WORDS);

  always_comb begin
    stb           = '0;
    stb.wrId      = valueWr && (indexQ == REG_ID);
    stb.wrEnable  = valueWr && (indexQ == REG_ENABLE);
    stb.wrWidth   = valueWr && (indexQ == REG_WIDTH);
    stb.wrHeight  = valueWr && (indexQ == REG_HEIGHT);
    stb.wrConfig  = valueWr && (indexQ == REG_CONFIG);
    stb.wrSync    = valueWr && (indexQ == REG_SYNC);
    stb.wrGuest   = valueWr && (indexQ == REG_GUEST);
    stb.wrCurId   = valueWr && (indexQ == REG_CUR_ID);
    stb.wrCurX    = valueWr && (indexQ == REG_CUR_X);
    stb.wrCurY    = valueWr && (indexQ == REG_CUR_Y);
    stb.wrCurOn   = valueWr && (indexQ == REG_CUR_ON);
    stb.wrScratch = valueWr && inScratch(indexQ, SCR_WORDS);
    stb.rdLoad    = isRead;
  end

  always_comb begin
    if (hitIndex)      rdSel = RD_INDEX;
    else if (hitValue) rdSel = RD_VALUE;
    else if (hitAux)   rdSel = RD_AUX;
    else               rdSel = RD_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      indexQ    <= '0;
      rdValid   <= 1'b0;
      rdErr     <= 1'b0;
      syncPulse <= 1'b0;
    end else begin
      if (busValid && busWrite && hitIndex) indexQ <= busWData;
      rdValid   <= isRead;
      rdErr     <= isRead && hitValue && !mapped;
      syncPulse <= stb.wrSync;
    end
  end

  // R11: an error flag never appears without read data
  assert_err_with_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> rdValid);

  // R12: a read request yields exactly one valid cycle
  assert_read_response_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |=> rdValid);

endmodule

// File: rtl/disp_idx_data.sv
module disp_idx_data
  import disp_idx_pkg::*;
#(
  parameter int          SCRATCH_WORDS = 64,
  parameter int          HOST_DEPTH    = 32,
  parameter int          RESET_WIDTH   = 640,
  parameter int          RESET_HEIGHT  = 480,
  parameter logic [31:0] CAPS_WORD     = 32'h0000_00E3,
  parameter logic [31:0] MEM_BYTES     = 32'h0001_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  dispStrobe_t stb,
  input  rdSel_e      rdSel,
  input  logic [31:0] indexQ,
  input  logic [31:0] busWData,
  input  logic        cmdDone,
  output logic [31:0] rdData,
  output logic        enableQ,
  output logic        configQ,
  output logic        busyQ
);

  localparam int          SCR_AW     = (SCRATCH_WORDS > 1) ? $clog2(SCRATCH_WORDS) : 1;
  localparam logic [31:0] SCR_WORDS  = 32'(SCRATCH_WORDS);
  localparam logic [31:0] DEPTH_W    = 32'(HOST_DEPTH);
  localparam logic [31:0] DEPTH_SHOW = (HOST_DEPTH == 32) ? 32'd24 : DEPTH_W;

  logic [31:0] idQ, widthQ, heightQ, guestQ, curIdQ, curXQ, curYQ;
  logic        curOnQ;
  logic [31:0] scratchMem [SCRATCH_WORDS];
  logic [SCR_AW-1:0] scrOff;
  logic [31:0] lineBytes, regValue, nextRd;

  assign scrOff    = SCR_AW'(indexQ - SCR_BASE);
  assign lineBytes = (widthQ * DEPTH_W) >> 3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idQ     <= VER_2;
      enableQ <= 1'b0;
      configQ <= 1'b0;
      busyQ   <= 1'b0;
      widthQ  <= 32'(RESET_WIDTH);
      heightQ <= 32'(RESET_HEIGHT);
      guestQ  <= '0;
      curIdQ  <= '0;
      curXQ   <= '0;
      curYQ   <= '0;
      curOnQ  <= 1'b0;
    end else begin
      if (stb.wrId && (busWData == VER_0 || busWData == VER_1 || busWData == VER_2))
        idQ <= busWData;
      if (stb.wrEnable) enableQ <= |busWData;
      if (stb.wrConfig) configQ <= |busWData;
      if (stb.wrWidth && busWData <= LIMIT_W)  widthQ  <= busWData;
      if (stb.wrHeight && busWData <= LIMIT_H) heightQ <= busWData;
      if (stb.wrGuest) guestQ <= busWData;
      if (stb.wrCurId) curIdQ <= busWData;
      if (stb.wrCurX)  curXQ  <= busWData;
      if (stb.wrCurY)  curYQ  <= busWData;
      if (stb.wrCurOn) begin
        if (busWData == 32'd1)      curOnQ <= 1'b1;
        else if (busWData == 32'd0) curOnQ <= 1'b0;
      end
      if (stb.wrSync)     busyQ <= 1'b1;
      else if (cmdDone)   busyQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SCRATCH_WORDS; i++) scratchMem[i] <= '0;
    end else if (stb.wrScratch) begin
      scratchMem[scrOff] <= busWData;
    end
  end

  always_comb begin
    case (indexQ)
      REG_ID:         regValue = idQ;
      REG_ENABLE:     regValue = {31'b0, enableQ};
      REG_WIDTH:      regValue = widthQ;
      REG_HEIGHT:     regValue = heightQ;
      REG_MAX_W:      regValue = LIMIT_W;
      REG_MAX_H:      regValue = LIMIT_H;
      REG_DEPTH:      regValue = DEPTH_SHOW;
      REG_BPP:        regValue = DEPTH_W;
      REG_LINE_BYTES: regValue = lineBytes;
      REG_CAPS:       regValue = CAPS_WORD;
      REG_MEM_SIZE:   regValue = MEM_BYTES;
      REG_CONFIG:     regValue = {31'b0, configQ};
      REG_BUSY:       regValue = {31'b0, busyQ};
      REG_GUEST:      regValue = guestQ;
      REG_CUR_ID:     regValue = curIdQ;
      REG_CUR_X:      regValue = curXQ;
      REG_CUR_Y:      regValue = curYQ;
      REG_CUR_ON:     regValue = {31'b0, curOnQ};
      REG_SCR_SIZE:   regValue = SCR_WORDS;
      default:        regValue = inScratch(indexQ, SCR_WORDS) ? scratchMem[scrOff] : 32'd0;
    endcase
  end

  always_comb begin
    case (rdSel)
      RD_INDEX: nextRd = indexQ;
      RD_VALUE: nextRd = regValue;
      RD_AUX:   nextRd = 32'd0;
      default:  nextRd = 32'hFFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (stb.rdLoad) rdData <= nextRd;
  end

  // R3: the version word only ever holds one of the three accepted codes
  assert_id_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    (idQ == VER_0) || (idQ == VER_1) || (idQ == VER_2));

  // R4: stored mode never exceeds the limits
  assert_width_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    widthQ <= LIMIT_W);
  assert_height_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    heightQ <= LIMIT_H);

  // R8: codes other than 0 and 1 leave the cursor flag alone
  assert_cursor_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCurOn && busWData > 32'd1) |=> $stable(curOnQ));

endmodule

// File: rtl/disp_idx_port.sv
module disp_idx_port
  import disp_idx_pkg::*;
#(
  parameter int          ADDR_W        = 4,
  parameter int          STRIDE        = 1,
  parameter int          SCRATCH_WORDS = 64,
  parameter int          HOST_DEPTH    = 32,
  parameter int          RESET_WIDTH   = 640,
  parameter int          RESET_HEIGHT  = 480,
  parameter logic [31:0] CAPS_WORD     = 32'h0000_00E3,
  parameter logic [31:0] MEM_BYTES     = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWData,
  input  logic              cmdDone,
  output logic              rdValid,
  output logic [31:0]       rdData,
  output logic              rdErr,
  output logic              dispEnable,
  output logic              dispConfig,
  output logic              syncPulse
);

  dispStrobe_t stb;
  rdSel_e      rdSel;
  logic [31:0] indexQ;
  logic        busyQ;

  disp_idx_ctrl #(
    .ADDR_W(ADDR_W), .STRIDE(STRIDE), .SCRATCH_WORDS(SCRATCH_WORDS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWData(busWData), .stb(stb), .rdSel(rdSel),
    .indexQ(indexQ), .rdValid(rdValid), .rdErr(rdErr), .syncPulse(syncPulse)
  );

  disp_idx_data #(
    .SCRATCH_WORDS(SCRATCH_WORDS), .HOST_DEPTH(HOST_DEPTH),
    .RESET_WIDTH(RESET_WIDTH), .RESET_HEIGHT(RESET_HEIGHT),
    .CAPS_WORD(CAPS_WORD), .MEM_BYTES(MEM_BYTES)
  ) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .indexQ(indexQ),
    .busWData(busWData), .cmdDone(cmdDone), .rdData(rdData),
    .enableQ(dispEnable), .configQ(dispConfig), .busyQ(busyQ)
  );

  // R7: a sync pulse is always seen with busy already set
  assert_sync_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    syncPulse |-> busyQ);

  // R11: an error read carries zero data
  assert_err_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> (rdData == 32'd0));

endmodule

// File: tb/disp_idx_port_tb.sv
module disp_idx_port_tb;

  localparam int ADDR_W = 4;
  localparam int STRIDE = 1;
  localparam logic [ADDR_W-1:0] A_IDX = 4'd0;
  localparam logic [ADDR_W-1:0] A_VAL = 4'd1;
  localparam logic [ADDR_W-1:0] A_AUX = 4'd2;
  localparam logic [ADDR_W-1:0] A_BAD = 4'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0, cmdDone = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWData = '0;
  logic rdValid, rdErr, dispEnable, dispConfig, syncPulse;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  disp_idx_port u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWData(busWData), .cmdDone(cmdDone),
    .rdValid(rdValid), .rdData(rdData), .rdErr(rdErr),
    .dispEnable(dispEnable), .dispConfig(dispConfig), .syncPulse(syncPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWData = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [ADDR_W-1:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
    chk("R12 rdValid", {31'b0, rdValid}, 32'd1);
    d = rdData; e = rdErr;
  endtask

  task automatic setReg(input logic [31:0] idx, input logic [31:0] v);
    busWr(A_IDX, idx);
    busWr(A_VAL, v);
  endtask

  task automatic getReg(input logic [31:0] idx, output logic [31:0] d, output logic e);
    busWr(A_IDX, idx);
    busRd(A_VAL, d, e);
  endtask

  function automatic logic [31:0] lineBytesOf(input logic [31:0] w);
    return (w * 32'd32) / 32'd8;
  endfunction

  function automatic logic cursorNext(input logic cur, input logic [31:0] code);
    if (code == 32'd1) return 1'b1;
    if (code == 32'd0) return 1'b0;
    return cur;
  endfunction

  initial begin
    logic [31:0] d;
    logic e;
    logic [31:0] wModel, hModel, v;
    logic curModel;
    logic [31:0] scrModel [64];
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) scrModel[i] = 32'd0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 enable", {31'b0, dispEnable}, 32'd0);
    chk("R1 config", {31'b0, dispConfig}, 32'd0);
    chk("R1 sync", {31'b0, syncPulse}, 32'd0);
    busRd(A_IDX, d, e); chk("R1 index", d, 32'd0);
    busRd(A_VAL, d, e); chk("R1 id", d, 32'h9000_0002);
    getReg(32'd2, d, e);  chk("R1 width", d, 32'd640);
    getReg(32'd3, d, e);  chk("R1 height", d, 32'd480);
    getReg(32'd22, d, e); chk("R1 busy", d, 32'd0);
    getReg(32'd27, d, e); chk("R1 cursor on", d, 32'd0);
    getReg(32'd25, d, e); chk("R1 cursor x", d, 32'd0);

    // R2 port offsets
    busWr(A_IDX, 32'd23);
    busRd(A_IDX, d, e); chk("R2 index readback", d, 32'd23);
    busRd(A_AUX, d, e); chk("R2 aux read", d, 32'd0);
    busWr(A_AUX, 32'd99);
    busRd(A_IDX, d, e); chk("R2 aux write ignored", d, 32'd23);
    busRd(A_BAD, d, e); chk("R2 other offset", d, 32'hFFFF_FFFF);

    // R3 version handshake
    setReg(32'd0, 32'h9000_0003);
    busRd(A_VAL, d, e); chk("R3 bad id kept", d, 32'h9000_0002);
    setReg(32'd0, 32'h9000_0000);
    busRd(A_VAL, d, e); chk("R3 id0", d, 32'h9000_0000);
    busWr(A_VAL, 32'h1234_5678);
    busRd(A_VAL, d, e); chk("R3 junk kept", d, 32'h9000_0000);
    busWr(A_VAL, 32'h9000_0001);
    busRd(A_VAL, d, e); chk("R3 id1", d, 32'h9000_0001);

    // R4 limits, directed edges then random
    setReg(32'd2, 32'd2368); busRd(A_VAL, d, e); chk("R4 width max", d, 32'd2368);
    busWr(A_VAL, 32'd2369);  busRd(A_VAL, d, e); chk("R4 width over", d, 32'd2368);
    setReg(32'd3, 32'd1770); busRd(A_VAL, d, e); chk("R4 height max", d, 32'd1770);
    busWr(A_VAL, 32'd1771);  busRd(A_VAL, d, e); chk("R4 height over", d, 32'd1770);
    wModel = 32'd2368; hModel = 32'd1770;
    for (int i = 0; i < 20; i++) begin
      v = $urandom_range(0, 4095);
      setReg(32'd2, v);
      if (v <= 32'd2368) wModel = v;
      busRd(A_VAL, d, e); chk("R4 random width", d, wModel);
      v = $urandom_range(0, 3000);
      setReg(32'd3, v);
      if (v <= 32'd1770) hModel = v;
      busRd(A_VAL, d, e); chk("R4 random height", d, hModel);
      getReg(32'd12, d, e); chk("R5 line bytes", d, lineBytesOf(wModel));
    end

    // R5 constants
    getReg(32'd4, d, e);  chk("R5 max width", d, 32'd2368);
    getReg(32'd5, d, e);  chk("R5 max height", d, 32'd1770);
    getReg(32'd6, d, e);  chk("R5 depth", d, 32'd24);
    getReg(32'd7, d, e);  chk("R5 bpp", d, 32'd32);
    getReg(32'd17, d, e); chk("R5 caps", d, 32'h0000_00E3);
    getReg(32'd19, d, e); chk("R5 mem size", d, 32'h0001_0000);
    getReg(32'd29, d, e); chk("R5 scratch size", d, 32'd64);
    chk("R5 no error", {31'b0, e}, 32'd0);

    // R6 enable and config
    setReg(32'd1, 32'd5);
    chk("R6 enable out", {31'b0, dispEnable}, 32'd1);
    busRd(A_VAL, d, e); chk("R6 enable read", d, 32'd1);
    busWr(A_VAL, 32'd0);
    chk("R6 enable cleared", {31'b0, dispEnable}, 32'd0);
    setReg(32'd20, 32'h8000_0000);
    chk("R6 config out", {31'b0, dispConfig}, 32'd1);
    busRd(A_VAL, d, e); chk("R6 config read", d, 32'd1);

    // R7 sync and busy
    busWr(A_IDX, 32'd21);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = A_VAL; busWData = 32'd1;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    chk("R7 pulse high", {31'b0, syncPulse}, 32'd1);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'b0, syncPulse}, 32'd0);
    getReg(32'd22, d, e); chk("R7 busy set", d, 32'd1);
    @(negedge clk); cmdDone = 1'b1;
    @(negedge clk); cmdDone = 1'b0;
    busRd(A_VAL, d, e); chk("R7 busy cleared", d, 32'd0);
    busWr(A_IDX, 32'd21);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = A_VAL; busWData = 32'd0; cmdDone = 1'b1;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; cmdDone = 1'b0;
    getReg(32'd22, d, e); chk("R7 set wins", d, 32'd1);

    // R8 cursor codes
    curModel = 1'b0;
    busWr(A_IDX, 32'd27);
    for (int i = 0; i < 30; i++) begin
      v = $urandom_range(0, 5);
      busWr(A_VAL, v);
      curModel = cursorNext(curModel, v);
      busRd(A_VAL, d, e); chk("R8 cursor on", d, {31'b0, curModel});
    end
    busWr(A_VAL, 32'd1); busWr(A_VAL, 32'd2);
    busRd(A_VAL, d, e); chk("R8 code2 keeps", d, 32'd1);
    busWr(A_VAL, 32'd0); busWr(A_VAL, 32'd3);
    busRd(A_VAL, d, e); chk("R8 code3 keeps", d, 32'd0);

    // R9 plain stores
    setReg(32'd23, 32'h0000_5008); busRd(A_VAL, d, e); chk("R9 guest", d, 32'h0000_5008);
    setReg(32'd24, 32'hDEAD_BEEF); busRd(A_VAL, d, e); chk("R9 cursor id", d, 32'hDEAD_BEEF);
    setReg(32'd25, 32'hFFFF_FFF0); busRd(A_VAL, d, e); chk("R9 cursor x", d, 32'hFFFF_FFF0);
    setReg(32'd26, 32'd77);        busRd(A_VAL, d, e); chk("R9 cursor y", d, 32'd77);

    // R10 scratch and palette
    for (int i = 0; i < 40; i++) begin
      int k;
      k = $urandom_range(0, 63);
      v = $urandom;
      setReg(32'd1792 + 32'(k), v);
      scrModel[k] = v;
      k = $urandom_range(0, 63);
      getReg(32'd1792 + 32'(k), d, e); chk("R10 scratch", d, scrModel[k]);
    end
    getReg(32'd1855, d, e); chk("R10 last scratch", d, scrModel[63]);
    chk("R10 last scratch no err", {31'b0, e}, 32'd0);
    setReg(32'd1024, 32'h55AA_55AA);
    busRd(A_VAL, d, e); chk("R10 palette reads 0", d, 32'd0);
    chk("R10 palette no err", {31'b0, e}, 32'd0);
    getReg(32'd1791, d, e); chk("R10 palette end no err", {31'b0, e}, 32'd0);

    // R11 unmapped
    getReg(32'd1856, d, e);
    chk("R11 past scratch data", d, 32'd0);
    chk("R11 past scratch err", {31'b0, e}, 32'd1);
    @(negedge clk);
    chk("R11 err one cycle", {31'b0, rdErr}, 32'd0);
    chk("R12 valid one cycle", {31'b0, rdValid}, 32'd0);
    getReg(32'd8, d, e);   chk("R11 index 8 err", {31'b0, e}, 32'd1);
    getReg(32'd900, d, e); chk("R11 index 900 err", {31'b0, e}, 32'd1);
    chk("R11 index 900 data", d, 32'd0);
    getReg(32'd2, d, e);   chk("R11 mapped no err", {31'b0, e}, 32'd0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule